// File: doc/BRIEF.md
# External Bus Transfer Master

This block is a synchronous bus master. It takes single read or write requests from an internal requester and runs each one on a shared external bus. The external bus has a one-cycle transfer-start strobe, a read/write line, an address, a data path in each direction, and two termination inputs: a normal acknowledge and an error acknowledge. The selected slave drives both of them. A configuration input selects a full 32-bit data bus or a 16-bit bus. In 16-bit mode the slave port sits on the upper half-lane, bits 31:16.

The master does not end a beat on the raw acknowledge. It ends the beat on a registered copy, so address and control stay driven for one cycle after the slave acknowledges. After a transfer ends, the next transfer-start normally waits one idle cycle. The one exception is a transfer that is marked as part of a run of small accesses: then the next start follows at once.

In 16-bit mode a 32-bit access needs two halves. An access with no chip-select runs as one two-beat burst with a single start strobe. An access with a chip-select runs as two separate transfers. The requester sees a one-cycle grant when its request is taken, then a one-cycle done pulse with an error flag and, for reads, the assembled read word.

Top module: `xbus_master`

## Requirements
- R1: `req_grant` is high in a cycle where `req_valid` is high and the master can accept. `xb_ts` is then high for exactly the following cycle. In that cycle `xb_addr` is the request address and `xb_rw` is 1 for a read and 0 for a write.
- R2: A beat ends one cycle after the cycle in which `xb_ack` is sampled high. `rsp_done` pulses in that cycle for the last beat. `xb_addr` and `xb_rw` keep their values through that cycle.
- R3: `xb_err` ends a beat with the same one-cycle delay as `xb_ack`, and `rsp_err` is high with `rsp_done`.
- R4: When the ending transfer is small (`req_wide`=0) and was issued with `req_cont`=1, a waiting request is granted in the ending cycle. Its `xb_ts` appears in the very next cycle.
- R5: In every other case, at least one cycle with `xb_ts` low separates the ending cycle from the next `xb_ts`. A request is not granted in the ending cycle. This includes a wide access issued with `req_cont`=1.
- R6: With `cfg_half_bus`=1, `req_wide`=1 and `req_nocs`=1, the access runs as a burst. There is one `xb_ts`, with `xb_burst`=1 in that cycle. The first beat carries bits 31:16 at the request address. The second beat carries bits 15:0 at address+2 and has no start strobe.
- R7: With `cfg_half_bus`=1, `req_wide`=1 and `req_nocs`=0, the access runs as two transfers. Each has its own `xb_ts` with `xb_burst`=0, and one idle cycle lies between the first transfer's end and the second start. The halves and addresses are ordered as in R6.
- R8: An error on either beat of a two-part access ends it at once with `rsp_done` and `rsp_err`, and no further `xb_ts` follows for it.
- R9: On a write, `xb_doe` is low in the start cycle and high from the next cycle through the ending cycle. On a 16-bit half-beat, `xb_dout` carries the current half in bits 31:16 and zero in bits 15:0. In every other case it carries the full write word.
- R10: Read data is taken from `xb_din` on the cycle `xb_ack` is high. On a half-beat, bits 31:16 of `xb_din` fill bits 31:16 of the result on the first beat and bits 15:0 of the result on the second. In every other case the whole word is taken. `rsp_rdata` is valid with `rsp_done`.
- R11: With `cfg_half_bus`=0, a 32-bit access is one beat with one `xb_ts` and no burst flag.
- R12: After reset, `xb_ts`, `xb_doe`, `rsp_done` and `req_grant` are low. `req_grant` stays low until `req_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_half_bus | input | 1 | 1 selects the 16-bit data bus |
| req_valid | input | 1 | request pending |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 32-bit access, 0 for a small access |
| req_nocs | input | 1 | access has no chip-select |
| req_cont | input | 1 | access continues a run of small accesses |
| req_addr | input | AW | byte address |
| req_wdata | input | 32 | write word |
| req_grant | output | 1 | request taken this cycle |
| rsp_done | output | 1 | access finished |
| rsp_err | output | 1 | access ended with an error |
| rsp_rdata | output | 32 | read word, valid with rsp_done |
| xb_ts | output | 1 | transfer start |
| xb_rw | output | 1 | 1 read, 0 write |
| xb_burst | output | 1 | two-beat burst flag, valid with xb_ts |
| xb_addr | output | AW | bus address |
| xb_dout | output | 32 | write data |
| xb_doe | output | 1 | write data drive enable |
| xb_din | input | 32 | read data |
| xb_ack | input | 1 | transfer acknowledge from slave |
| xb_err | input | 1 | transfer error acknowledge from slave |

## Verification
Grant is combinational on the request and is due in the same cycle. The start strobe is due one cycle after the grant. Write-drive starts one cycle after the start strobe. Done, error and read data are due one cycle after the acknowledge is driven, and the next start is due either in the cycle after the ending cycle or one cycle later. The bench plays the slave by driving the acknowledge on the falling edge. It samples each output on a falling edge at exactly the offset listed above, and checks combinational grant one time step after the request inputs change.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_DW = 32;
  localparam int XB_HW = XB_DW / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_GAP,
    ST_SGAP
  } xb_state_e;

  // Place one half of a word on the upper lane of a half-width bus.
  function automatic logic [XB_DW-1:0] half_on_upper(input logic [XB_DW-1:0] w,
                                                     input logic low_half);
    logic [XB_HW-1:0] h;
    h = low_half ? w[XB_HW-1:0] : w[XB_DW-1:XB_HW];
    return {h, {XB_HW{1'b0}}};
  endfunction

  // Fold an upper-lane half read into an assembled word.
  function automatic logic [XB_DW-1:0] fold_half(input logic [XB_DW-1:0] old,
                                                 input logic [XB_DW-1:0] din,
                                                 input logic low_half);
    logic [XB_DW-1:0] r;
    r = old;
    if (low_half) r[XB_HW-1:0] = din[XB_DW-1:XB_HW];
    else          r[XB_DW-1:XB_HW] = din[XB_DW-1:XB_HW];
    return r;
  endfunction
endpackage

// File: rtl/xbus_ack_reg.sv
module xbus_ack_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic err_in,
  output logic ack_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ack_in;
      err_q <= err_in;
    end
  end
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_beat,
  input  logic             low_half,
  input  logic             cap_en,
  input  logic             drive_en,
  input  logic [XB_DW-1:0] wdata,
  input  logic [XB_DW-1:0] din,
  output logic [XB_DW-1:0] dout,
  output logic [XB_DW-1:0] rdata
);
  logic [XB_DW-1:0] lane_w;

  always_comb begin
    lane_w = half_beat ? half_on_upper(wdata, low_half) : wdata;
    dout   = drive_en ? lane_w : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (cap_en) rdata <= half_beat ? fold_half(rdata, din, low_half) : din;
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_half_bus,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic             req_nocs,
  input  logic             req_cont,
  input  logic [AW-1:0]    req_addr,
  input  logic [XB_DW-1:0] req_wdata,
  output logic             req_grant,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [XB_DW-1:0] rsp_rdata,
  output logic             xb_ts,
  output logic             xb_rw,
  output logic             xb_burst,
  output logic [AW-1:0]    xb_addr,
  output logic [XB_DW-1:0] xb_dout,
  output logic             xb_doe,
  input  logic [XB_DW-1:0] xb_din,
  input  logic             xb_ack,
  input  logic             xb_err
);
  localparam logic [AW-1:0] HALF_STEP = AW'(XB_HW / 8);

  xb_state_e        state_q, state_d;
  logic             cur_write, cur_wide, cur_nocs, cur_cont, cur_half;
  logic             beat_q;
  logic [AW-1:0]    addr_q;
  logic [XB_DW-1:0] wdata_q;
  logic             ack_q, err_q;

  // Named internal events
  logic two_part, burst_mode, term, last_beat, fin, cont_ok, accept, cap_en;

  xbus_ack_reg u_ackreg (
    .clk(clk), .rst_n(rst_n), .ack_in(xb_ack), .err_in(xb_err),
    .ack_q(ack_q), .err_q(err_q)
  );

  always_comb begin
    two_part   = cur_half && cur_wide;
    burst_mode = two_part && cur_nocs;
    term       = (state_q == ST_DATA) && (ack_q || err_q);
    last_beat  = !two_part || beat_q || err_q;
    fin        = term && last_beat;
    cont_ok    = cur_cont && !cur_wide && !err_q;
    accept     = req_valid && ((state_q == ST_IDLE) || (state_q == ST_GAP) ||
                               (fin && cont_ok));
    cap_en     = (state_q == ST_DATA) && xb_ack && !xb_err && !cur_write;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_GAP: state_d = accept ? ST_START : ST_IDLE;
      ST_START:        state_d = ST_DATA;
      ST_DATA: begin
        if (term) begin
          if (!last_beat)  state_d = burst_mode ? ST_DATA : ST_SGAP;
          else if (accept) state_d = ST_START;
          else             state_d = ST_GAP;
        end
      end
      ST_SGAP:         state_d = ST_START;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_write <= 1'b0;
      cur_wide  <= 1'b0;
      cur_nocs  <= 1'b0;
      cur_cont  <= 1'b0;
      cur_half  <= 1'b0;
      beat_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_write <= req_write;
        cur_wide  <= req_wide;
        cur_nocs  <= req_nocs;
        cur_cont  <= req_cont;
        cur_half  <= cfg_half_bus;
        beat_q    <= 1'b0;
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
      end else if (term && !last_beat) begin
        beat_q <= 1'b1;
        addr_q <= addr_q + HALF_STEP;
      end
    end
  end

  xbus_lane u_lane (
    .clk(clk), .rst_n(rst_n), .half_beat(two_part), .low_half(beat_q),
    .cap_en(cap_en), .drive_en(xb_doe), .wdata(wdata_q), .din(xb_din),
    .dout(xb_dout), .rdata(rsp_rdata)
  );

  assign req_grant = accept;
  assign rsp_done  = fin;
  assign rsp_err   = fin && err_q;
  assign xb_ts     = (state_q == ST_START);
  assign xb_burst  = xb_ts && burst_mode;
  assign xb_rw     = !cur_write;
  assign xb_addr   = addr_q;
  assign xb_doe    = (state_q == ST_DATA) && cur_write;

  AST_TS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xb_ts |=> !xb_ts); // R1
  AST_GRANT_TO_TS: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> xb_ts); // R1
  AST_END_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(xb_ack || xb_err)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> ($stable(xb_addr) && $stable(xb_rw))); // R2
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |=> !xb_ts); // R8
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !(cur_cont && !cur_wide)) |=> !xb_ts); // R5
  AST_NO_DRIVE_AT_TS: assert property (@(posedge clk) disable iff (!rst_n)
    xb_ts |-> !xb_doe); // R9
endmodule

// File: tb/xbus_master_test.sv
module xbus_master_test;
  localparam int CLK_P = 10;
  localparam int AW = 24;

  typedef struct packed {
    logic        half;
    logic        wr;
    logic        wide;
    logic        nocs;
    logic [1:0]  errb;   // 0 none, 1 first beat, 2 second beat
    logic [23:0] addr;
    logic [31:0] wd;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 24'h000100, 32'h0, 32'hA1B2C3D4, 32'h0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 24'h000204, 32'h11223344, 32'h0, 32'h0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 24'h001000, 32'h0, 32'hBEEF1234, 32'hCAFE5678},
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 24'h002000, 32'hDEADBEEF, 32'h0, 32'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 24'h003000, 32'h0, 32'h12340000, 32'h56780000},
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 24'h004000, 32'h55667788, 32'h0, 32'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 24'h005000, 32'h0, 32'h9ABC0000, 32'h0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 24'h006002, 32'h0000ABCD, 32'h0, 32'h0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 24'h007000, 32'h0, 32'h0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_half_bus = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_nocs = 1'b0, req_cont = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_grant, rsp_done, rsp_err, xb_ts, xb_rw, xb_burst, xb_doe;
  logic [31:0] rsp_rdata, xb_dout;
  logic [AW-1:0] xb_addr;
  logic [31:0] xb_din = '0;
  logic xb_ack = 1'b0, xb_err = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  xbus_master #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_half_bus(cfg_half_bus),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_nocs(req_nocs), .req_cont(req_cont), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_grant(req_grant), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .xb_ts(xb_ts), .xb_rw(xb_rw),
    .xb_burst(xb_burst), .xb_addr(xb_addr), .xb_dout(xb_dout), .xb_doe(xb_doe),
    .xb_din(xb_din), .xb_ack(xb_ack), .xb_err(xb_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lane(input vec_t v, input int b);
    if (v.half && v.wide) return b == 0 ? {v.wd[31:16], 16'h0} : {v.wd[15:0], 16'h0};
    return v.wd;
  endfunction

  // Issue one access and play the slave; returns in the ending cycle.
  task automatic run_xfer(input vec_t v, input logic cont);
    logic two, split, is_err, lastb;
    int nb;
    logic [31:0] exp_rd;
    two = v.half && v.wide;
    split = two && !v.nocs;
    nb = two ? 2 : 1;
    exp_rd = two ? {v.d0[31:16], v.d1[31:16]} : v.d0;
    cfg_half_bus = v.half; req_write = v.wr; req_wide = v.wide; req_nocs = v.nocs;
    req_cont = cont; req_addr = v.addr; req_wdata = v.wd; req_valid = 1'b1;
    #1 chk("R1 R4 grant", 32'(req_grant), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      if (b > 0) begin
        @(negedge clk);
        if (split) begin
          chk("R7 idle between halves", 32'(xb_ts), 32'd0);
          @(negedge clk);
        end
      end
      if (b == 0 || split) begin
        chk("R1 ts", 32'(xb_ts), 32'd1);
        chk("R1 rw", 32'(xb_rw), 32'(!v.wr));
        chk("R6 R7 R11 burst flag", 32'(xb_burst), 32'(two && v.nocs));
        chk("R9 no drive at start", 32'(xb_doe), 32'd0);
        @(negedge clk);
      end else begin
        chk("R6 no start on beat two", 32'(xb_ts), 32'd0);
      end
      chk("R6 R7 beat addr", 32'(xb_addr), 32'(v.addr + 24'(2 * b)));
      chk("R9 drive enable", 32'(xb_doe), 32'(v.wr));
      if (v.wr) chk("R9 write lane", xb_dout, exp_lane(v, b));
      is_err = (int'(v.errb) == b + 1);
      xb_ack = !is_err; xb_err = is_err; xb_din = (b == 0) ? v.d0 : v.d1;
      chk("R2 not ended on raw ack", 32'(rsp_done), 32'd0);
      @(negedge clk);
      xb_ack = 1'b0; xb_err = 1'b0; xb_din = '0;
      lastb = (b == nb - 1) || is_err;
      chk(two ? "R2 R6 done" : "R2 R11 done", 32'(rsp_done), 32'(lastb));
      chk("R2 addr held", 32'(xb_addr), 32'(v.addr + 24'(2 * b)));
      chk("R2 rw held", 32'(xb_rw), 32'(!v.wr));
      if (v.wr) chk("R9 drive through end", 32'(xb_doe), 32'd1);
      if (lastb) chk("R3 R8 err flag", 32'(rsp_err), 32'(is_err));
      if (lastb && !is_err && !v.wr) chk("R10 read data", rsp_rdata, exp_rd);
      if (is_err) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t sm;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ts", 32'(xb_ts), 32'd0);
    chk("R12 done", 32'(rsp_done), 32'd0);
    chk("R12 doe", 32'(xb_doe), 32'd0);
    chk("R12 grant", 32'(req_grant), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle grant", 32'(req_grant), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_xfer(TBL[i], 1'b0);
      @(negedge clk);
      chk("R5 R8 idle after end", 32'(xb_ts), 32'd0);
      @(negedge clk);
    end

    // R4: continuing small accesses start back to back
    sm = '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 24'h008000, 32'h0, 32'h0BAD0BAD, 32'h0};
    run_xfer(sm, 1'b1);
    sm.addr = 24'h008004; sm.d0 = 32'h600DF00D;
    run_xfer(sm, 1'b0);   // grant expected in the ending cycle (R4)

    // R5: non-continuing small access waits one idle cycle
    req_valid = 1'b1; #1 chk("R5 no grant at end", 32'(req_grant), 32'd0);
    @(negedge clk);
    chk("R5 no start after end", 32'(xb_ts), 32'd0);
    sm.addr = 24'h008008;
    run_xfer(sm, 1'b0);

    // R5: wide access with cont flag is not a continuing run
    sm.wide = 1'b1; sm.addr = 24'h009000;
    @(negedge clk); @(negedge clk);
    run_xfer(sm, 1'b1);
    req_valid = 1'b1; #1 chk("R5 wide cont no grant", 32'(req_grant), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R5 wide cont idle", 32'(xb_ts), 32'd0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule